// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic 24-bit down-counter that serves as the heartbeat of an operating system. Software programs a start count, picks whether the counter advances on every processor clock or only on pulses from a slower reference, and enables it. The counter runs down to zero and reloads itself without software help. Each pass through zero leaves a sticky flag and, if software asked for it, a one-cycle interrupt request.

Four 32-bit words sit on a simple single-cycle register bus. A read returns data in the same cycle. A write takes effect at the next clock edge. The words are control/status, start count, live count and a read-only calibration word. The calibration word reports whether a reference exists, whether the 10 ms figure is exact, and the count that gives 10 ms. These three values are fixed by module parameters.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the enable, interrupt-enable, source and flag bits are 0, the start count and live count are 0, and `irq` is low. When the no-reference parameter is set, the control/status word therefore reads 0x4, otherwise 0x0.
- R2: `bus_addr[3:2]` selects the word: 0 is control/status, 1 is start count, 2 is live count, 3 is calibration. `bus_addr[1:0]` is ignored. A read (`bus_sel`=1, `bus_wr`=0) returns data combinationally in the same cycle.
- R3: The control/status word holds enable at bit 0, interrupt enable at bit 1, source at bit 2 (1 = every clock, 0 = reference tick) and the flag at bit 16. All other bits read 0. The start-count and live-count words read 0 in bits 31:24.
- R4: An enabled counter steps on every cycle when the source is 1. When the source is 0 it steps only in cycles with `ref_tick`=1. A disabled counter holds its value.
- R5: A step from N>1 gives N-1. A step from 1 gives 0, sets the flag and, if interrupt enable is 1, pulses `irq` high for exactly one cycle. That pulse coincides with the live count first reading 0. A step from 0 loads the start count and raises no event.
- R6: With a start count of 0, an enabled counter never sets the flag and never pulses `irq`.
- R7: A control/status read clears the flag at the clock edge that ends the read. If the flag is being set in that same cycle, it stays set.
- R8: A write of any data to the live-count word zeroes the count and the flag at the next edge and suppresses any `irq` from that cycle. This write takes priority over a step in the same cycle.
- R9: The calibration word reads {no-reference, skew, 6'b0, ten-ms count} from parameters. Writes to it change nothing.
- R10: When the no-reference parameter is 1, the source bit reads 1 whatever is written, and the counter steps on every clock regardless of `ref_tick`.
- R11: Writing the start count does not change the live count. The new value is used at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ref_tick | input | 1 | Synchronized one-cycle reference pulse |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Two pairs of events can land on the same edge. The first is a flag-setting step from 1 to 0 together with a control/status read, where the set must win. The second is a live-count write together with a counting step, where the write must win and no interrupt may leak. Directed sequences build each case on purpose: a start count of 2 is loaded and the read or write is placed on the third step. Long random runs with small start counts then hit both collisions many times. A cycle-level model in the bench predicts every read word and the `irq` level in every cycle, and both outputs are compared against it.

// File: rtl/sys_tick_timer.sv
module sys_tick_timer #(
  parameter int              CNT_W  = 24,
  parameter bit              NO_REF = 1'b0,
  parameter bit              SKEW   = 1'b0,
  parameter logic [CNT_W-1:0] TENMS = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ref_tick,
  output logic        irq
);
  localparam int PAD = 32 - CNT_W;

  logic [1:0]       idx;
  logic             rd, wr, rd_ctl, wr_ctl, wr_rl, wr_cur;
  logic             en_q, ti_q, cs_q, flag_q, cs_eff, step, hit;
  logic [CNT_W-1:0] rl_q, cur_q;

  assign idx    = bus_addr[3:2];
  assign rd     = bus_sel & ~bus_wr;
  assign wr     = bus_sel & bus_wr;
  assign rd_ctl = rd & (idx == 2'd0);
  assign wr_ctl = wr & (idx == 2'd0);
  assign wr_rl  = wr & (idx == 2'd1);
  assign wr_cur = wr & (idx == 2'd2);
  assign cs_eff = NO_REF | cs_q;
  assign step   = en_q & (cs_eff | ref_tick);
  assign hit    = step & (cur_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ti_q   <= 1'b0;
      cs_q   <= 1'b0;
      flag_q <= 1'b0;
      rl_q   <= '0;
      cur_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_ctl) begin
        en_q <= bus_wdata[0];
        ti_q <= bus_wdata[1];
        cs_q <= bus_wdata[2];
      end
      if (wr_rl) rl_q <= bus_wdata[CNT_W-1:0];
      if (wr_cur)    cur_q <= '0;
      else if (step) cur_q <= (cur_q == '0) ? rl_q : cur_q - CNT_W'(1);
      if (wr_cur)      flag_q <= 1'b0;
      else if (hit)    flag_q <= 1'b1;
      else if (rd_ctl) flag_q <= 1'b0;
      irq <= hit & ti_q & ~wr_cur;
    end
  end

  always_comb begin
    case (idx)
      2'd0:    bus_rdata = {15'd0, flag_q, 13'd0, cs_eff, ti_q, en_q};
      2'd1:    bus_rdata = {{PAD{1'b0}}, rl_q};
      2'd2:    bus_rdata = {{PAD{1'b0}}, cur_q};
      default: bus_rdata = {NO_REF, SKEW, {(PAD-2){1'b0}}, TENMS};
    endcase
  end

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cur_q == '0) && flag_q); // R5
  AST_IRQ_NEEDS_TI: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ti_q)); // R5
  AST_CUR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur |=> (cur_q == '0) && !flag_q && !irq); // R8
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cur) |=> $stable(cur_q)); // R4
  AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctl && !hit) |=> !flag_q); // R7
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctl && hit) |=> flag_q); // R7
endmodule

// File: tb/sim_sys_tick_timer.sv
module sim_sys_tick_timer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, sel, wr, tick;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;

  sys_tick_timer #(.NO_REF(1'b0), .SKEW(1'b1), .TENMS(24'd12345)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd0), .ref_tick(tick), .irq(irq0));
  sys_tick_timer #(.NO_REF(1'b1), .SKEW(1'b0), .TENMS(24'd40000)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd1), .ref_tick(1'b0), .irq(irq1));

  int checks = 0, fails = 0;
  logic        m_en[2], m_ti[2], m_cs[2], m_fl[2], m_irq[2];
  logic [23:0] m_rl[2], m_cur[2];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(int k, logic [1:0] idx);
    logic cs;
    cs = (k == 1) ? 1'b1 : m_cs[k];
    case (idx)
      2'd0:    return {15'd0, m_fl[k], 13'd0, cs, m_ti[k], m_en[k]};
      2'd1:    return {8'd0, m_rl[k]};
      2'd2:    return {8'd0, m_cur[k]};
      default: return (k == 0) ? {2'b01, 6'd0, 24'd12345} : {2'b10, 6'd0, 24'd40000};
    endcase
  endfunction

  function automatic string tag(int k, logic [3:0] a);
    if (a[1:0] != 2'b00) return "R2";
    case (a[3:2])
      2'd0:    return (k == 1) ? "R10" : "R3 R7";
      2'd1:    return "R11";
      2'd2:    return "R4 R5 R6 R8";
      default: return "R9";
    endcase
  endfunction

  task automatic op(logic s, logic w, logic [3:0] a, logic [31:0] d, logic t);
    sel = s; wr = w; addr = a; wdata = d; tick = t;
    #1;
    check("R5 R6 irq u0", {31'd0, irq0}, {31'd0, m_irq[0]});
    check("R5 R10 irq u1", {31'd0, irq1}, {31'd0, m_irq[1]});
    if (s && !w) begin
      check(tag(0, a), rd0, exp_rd(0, a[3:2]));
      check(tag(1, a), rd1, exp_rd(1, a[3:2]));
    end
    for (int k = 0; k < 2; k++) begin
      logic tk, cs, stp, set, nfl, nirq;
      logic [23:0] ncur;
      tk   = (k == 0) ? t : 1'b0;
      cs   = (k == 1) | m_cs[k];
      stp  = m_en[k] && (cs || tk);
      set  = stp && (m_cur[k] == 24'd1);
      ncur = m_cur[k];
      if (stp) ncur = (m_cur[k] == 24'd0) ? m_rl[k] : m_cur[k] - 24'd1;
      nfl  = set ? 1'b1 : ((s && !w && a[3:2] == 2'd0) ? 1'b0 : m_fl[k]);
      nirq = set && m_ti[k];
      if (s && w && a[3:2] == 2'd2) begin ncur = 24'd0; nfl = 1'b0; nirq = 1'b0; end
      if (s && w && a[3:2] == 2'd0) begin m_en[k] = d[0]; m_ti[k] = d[1]; m_cs[k] = d[2]; end
      if (s && w && a[3:2] == 2'd1) m_rl[k] = d[23:0];
      m_cur[k] = ncur; m_fl[k] = nfl; m_irq[k] = nirq;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, logic t);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 4'h0, 32'd0, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_en[k] = 0; m_ti[k] = 0; m_cs[k] = 0; m_fl[k] = 0; m_irq[k] = 0;
      m_rl[k] = 0; m_cur[k] = 0;
    end
    rst_n = 1'b0; sel = 1'b1; wr = 1'b0; addr = 4'h0; wdata = 0; tick = 0;
    repeat (2) @(negedge clk);
    #1;
    check("R1 u0 ctl", rd0, 32'h0);
    check("R1 R10 u1 ctl", rd1, 32'h4);
    check("R1 irq", {30'd0, irq1, irq0}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) op(1'b1, 1'b0, 4'(i), 32'd0, 1'b0);
    op(1'b1, 1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0);
    op(1'b1, 1'b0, 4'hC, 32'd0, 1'b0);
    op(1'b1, 1'b1, 4'h4, 32'hFF00_0003, 1'b0);
    op(1'b1, 1'b1, 4'h0, 32'hFFFF_FFF7, 1'b0);
    for (int i = 0; i < 12; i++) op(1'b1, 1'b0, 4'h8, 32'd0, 1'b0);
    op(1'b1, 1'b1, 4'h4, 32'd2, 1'b0);
    op(1'b1, 1'b1, 4'h8, 32'h1234, 1'b0);
    idle(2, 1'b0);
    op(1'b1, 1'b0, 4'h0, 32'd0, 1'b0);
    op(1'b1, 1'b0, 4'h0, 32'd0, 1'b0);
    op(1'b1, 1'b0, 4'h0, 32'd0, 1'b0);
    op(1'b1, 1'b1, 4'h8, 32'd7, 1'b0);
    idle(2, 1'b0);
    op(1'b1, 1'b1, 4'h8, 32'd9, 1'b0);
    op(1'b1, 1'b0, 4'h0, 32'd0, 1'b0);
    op(1'b1, 1'b1, 4'h4, 32'd0, 1'b0);
    for (int i = 0; i < 10; i++) op(1'b1, 1'b0, 4'h8, 32'd0, 1'b0);
    op(1'b1, 1'b0, 4'h0, 32'd0, 1'b0);
    op(1'b1, 1'b1, 4'h4, 32'd4, 1'b0);
    op(1'b1, 1'b1, 4'h0, 32'd3, 1'b0);
    for (int i = 0; i < 20; i++) op(1'b1, 1'b0, 4'h8, 32'd0, 1'(i % 3 == 0));
    op(1'b1, 1'b1, 4'h0, 32'd0, 1'b0);
    for (int i = 0; i < 5; i++) op(1'b1, 1'b0, 4'h8, 32'd0, 1'b1);

    void'($urandom(32'd2024));
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [3:0]  a;
      logic [31:0] d;
      r = int'($urandom % 10);
      a = 4'($urandom);
      d = $urandom;
      if (a[3:2] == 2'd1) d = $urandom % 7;
      if (a[3:2] == 2'd0 && ($urandom % 4) != 0) d[0] = 1'b1;
      if (r < 4)      op(1'b0, 1'b0, a, d, 1'($urandom % 3 == 0));
      else if (r < 8) op(1'b1, 1'b0, a, d, 1'($urandom % 3 == 0));
      else            op(1'b1, 1'b1, a, d, 1'($urandom % 3 == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule